// File: doc/BRIEF.md
# Serial-Commanded Parallel Memory Page Reader

This block lets a host read a byte-wide parallel memory over a serial line. It has a 15-bit address port and an 8-bit data port. The host sends one command byte over an asynchronous serial link. The block takes that byte as a page index, drives each address of the selected 256-byte page in ascending order, and captures the memory's data for each one. It returns every captured byte to the host over the same link.

The memory is treated as a plain asynchronous read device. Its read mode is held by static pins outside the block. For each address the block waits a set number of clock cycles before it samples the data port, which covers the device's access time. Between the sequencer and the transmitter there is an internal valid/ready handoff. The sequencer holds one captured byte and offers it until the transmitter is idle and accepts it. The address does not advance before that handoff, so there is no storage beyond one byte.

While a page is being returned, the block stays busy until the stop bit of the last byte has been sent. A command that arrives during that time is discarded. A received frame whose stop bit is low is also discarded.

Top module: `prom_page_uart`

## Requirements
- R1: After reset the serial output is high (line idle) and the address output is 0.
- R2: A command byte C selects page base address C[6:0] × 256. Bit 7 of the command is ignored, so command 0x80 reads page 0 and command 0xFF reads page 127.
- R3: Each accepted command returns exactly 256 bytes. Byte k is the memory content at base + k, for k from 0 to 255, in ascending order.
- R4: The data port is sampled only after the address has been held steady for SETTLE_CYCLES consecutive clock cycles.
- R5: Both serial directions use 8N1 framing: one low start bit, eight data bits least significant bit first, and one high stop bit. Each bit lasts CLKS_PER_BIT clock cycles.
- R6: A command byte that completes while the block is busy is dropped. Busy lasts from acceptance of a command until the last byte's stop bit has been sent. A dropped command has no effect on the bytes returned or on the address sequence.
- R7: A received frame whose stop bit is sampled low is discarded. It produces no response, and the address output does not change.
- R8: A captured byte passes to the transmitter only when the transmitter reports ready (idle). Until that handoff, the sequencer keeps offering the same byte and holds the address steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_rx_i | input | 1 | Serial command input from the host, idle high |
| ser_tx_o | output | 1 | Serial data output to the host, idle high |
| mem_addr_o | output | 15 | Address driven to the parallel memory |
| mem_data_i | input | 8 | Data returned by the parallel memory |

## Verification
The two functions that can coincide are the completion of a command on the receiver and the handoff of a captured byte to the transmitter. When they fall in the same cycle, the command must be dropped while the handoff and the address increment still take place. The bench provokes this by sending a second command a few bytes into a page. It then requires exactly 256 returned bytes that match the first page, and silence afterwards. The memory model returns wrong data until an address has been steady for the settle time, so any early sample or address slip shows up as a byte mismatch.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_OFFER,
    SQ_DRAIN
  } seq_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/prr_uart_rx.sv
module prr_uart_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] byte_o
);
  import prr_pkg::*;

  localparam int CW      = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF_M1 = (CLKS_PER_BIT / 2 > 0) ? CLKS_PER_BIT / 2 - 1 : 0;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    shift_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      valid_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CW'(HALF_M1)) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[7:1]};
            if (bit_q == 3'd7) state_q <= RX_STOP;
            else               bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            valid_o <= rx_s;
            byte_o  <= shift_q;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // R7: a byte is reported only at the end of a stop bit
  a_r7_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(state_q == RX_STOP));
endmodule

// File: rtl/prr_uart_tx.sv
module prr_uart_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       txd_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic          busy_q;
  logic [9:0]    frame_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    nbit_q;

  assign ready_o = !busy_q;
  assign txd_o   = busy_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
      nbit_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q  <= 1'b1;
        frame_q <= {1'b1, data_i, 1'b0};
        cnt_q   <= '0;
        nbit_q  <= '0;
      end
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_q   <= '0;
      frame_q <= {1'b1, frame_q[9:1]};
      if (nbit_q == 4'd9) busy_q <= 1'b0;
      else                nbit_q <= nbit_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: an accepted byte starts with a low start bit on the next cycle
  a_r5_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> (!txd_o && !ready_o));
endmodule

// File: rtl/prr_page_seq.sv
module prr_page_seq #(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int PAGE_BITS     = 8,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  import prr_pkg::*;

  localparam int IDX_W = ADDR_W - PAGE_BITS;
  localparam int SW    = $clog2(SETTLE_CYCLES + 1);

  seq_state_t        state_q;
  logic [SW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;
  logic              last_byte;

  assign mem_addr_o = addr_q;
  assign tx_data_o  = hold_q;
  assign tx_valid_o = (state_q == SQ_OFFER);
  assign last_byte  = &addr_q[PAGE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (cmd_valid_i) begin
          addr_q  <= ADDR_W'({cmd_byte_i, {PAGE_BITS{1'b0}}});
          cnt_q   <= '0;
          state_q <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (cnt_q == SW'(SETTLE_CYCLES - 1)) begin
            hold_q  <= mem_data_i;
            state_q <= SQ_OFFER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_OFFER: if (tx_ready_i) begin
          if (last_byte) begin
            state_q <= SQ_DRAIN;
          end else begin
            addr_q  <= addr_q + 1'b1;
            cnt_q   <= '0;
            state_q <= SQ_SETTLE;
          end
        end
        SQ_DRAIN: if (tx_ready_i) state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  // R2: an accepted command places the address at the start of the page
  a_r2_page_base: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && cmd_valid_i) |=>
      (mem_addr_o[PAGE_BITS-1:0] == '0 &&
       mem_addr_o[ADDR_W-1:PAGE_BITS] == $past(cmd_byte_i[IDX_W-1:0])));

  // R4: the address does not move while waiting to sample
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SETTLE && $past(state_q == SQ_SETTLE)) |-> $stable(mem_addr_o));

  // R8: a refused offer keeps the byte and the address
  a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(mem_addr_o)));

  // R6: a command during a busy period moves nothing except through a handoff
  a_r6_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && state_q != SQ_IDLE && !(tx_valid_o && tx_ready_i)) |=> $stable(mem_addr_o));
endmodule

// File: rtl/prom_page_uart.sv
module prom_page_uart #(
  parameter int CLKS_PER_BIT  = 16,
  parameter int SETTLE_CYCLES = 3,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int PAGE_BITS     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_rx_i,
  output logic              ser_tx_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i
);
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready;

  prr_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd_i(ser_rx_i),
    .valid_o(cmd_valid), .byte_o(cmd_byte)
  );

  prr_page_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_BITS(PAGE_BITS), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  prr_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .valid_i(tx_valid), .data_i(tx_data),
    .ready_o(tx_ready), .txd_o(ser_tx_o)
  );
endmodule

// File: tb/test_prom_page_uart.sv
module test_prom_page_uart;
  localparam int CPB    = 4;
  localparam int SETTLE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic        txd;
  logic [14:0] addr;
  logic [7:0]  mdata = 8'h00;

  int n_chk = 0, n_fail = 0;
  int rx_count = 0;
  logic [7:0] got [0:511];
  logic [7:0] salt;
  logic [14:0] last_addr = '0;
  int age = 100;
  bit finished = 0;

  always #4 clk = ~clk;

  prom_page_uart #(.CLKS_PER_BIT(CPB), .SETTLE_CYCLES(SETTLE)) i_prom_page_uart (
    .clk(clk), .rst_n(rst_n), .ser_rx_i(rxd), .ser_tx_o(txd),
    .mem_addr_o(addr), .mem_data_i(mdata)
  );

  function automatic logic [7:0] mem_val(input logic [14:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd29) ^ {1'b0, a[14:8]} ^ s;
  endfunction

  // memory model: correct data only once the address has been steady long enough
  always @(negedge clk) begin
    if (addr != last_addr) begin
      age = 1;
      last_addr = addr;
    end else if (age < 1000) begin
      age = age + 1;
    end
    mdata = (age >= SETTLE) ? mem_val(addr, salt) : ~mem_val(addr, salt);
  end

  // host-side serial receiver
  initial begin
    forever begin
      @(negedge clk);
      if (!txd && rst_n) begin
        logic [7:0] b;
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        n_chk++;
        if (!txd) begin
          n_fail++;
          $display("FAIL R5 stop bit actual=%0b expected=1", txd);
        end
        if (rx_count < 512) got[rx_count] = b;
        rx_count++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit good_stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = good_stop;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic wait_bytes(input int n);
    int t = 0;
    while (rx_count < n && t < 30000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // R2 R3 R4: one page command, then compare every returned byte
  task automatic run_page(input logic [7:0] cmd, input string tag);
    logic [14:0] base = {cmd[6:0], 8'h00};
    int bad = 0, first_bad = -1;
    rx_count = 0;
    send(cmd, 1'b1);
    wait_bytes(256);
    repeat (200) @(negedge clk);
    chk(rx_count == 256, {tag, " R3 byte count"}, rx_count, 256);
    for (int k = 0; k < 256; k++) begin
      if (got[k] !== mem_val(base + 15'(k), salt)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    if (first_bad >= 0)
      chk(1'b0, {tag, " R2/R4 data at offset"}, int'(got[first_bad]),
          int'(mem_val(base + 15'(first_bad), salt)));
    else
      chk(1'b1, {tag, " R2/R4 data"}, 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [14:0] a_before;
    void'($urandom(32'd2024));
    salt = 8'($urandom());
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 tx idle", txd, 1);
    chk(addr == 15'd0, "R1 address", addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners, including R2 MSB ignored
    run_page(8'h00, "page00");
    run_page(8'hFF, "pageFF_R2_msb");
    chk(addr == 15'h7FFF, "R2 last address of page 127", addr, 15'h7FFF);
    run_page(8'h80, "page80_R2_msb");
    // random pages
    for (int i = 0; i < 3; i++) begin
      salt = 8'($urandom());
      run_page(8'($urandom()), "random");
    end

    // R6: second command while streaming must be dropped
    rx_count = 0;
    send(8'h12, 1'b1);
    wait_bytes(3);
    send(8'h45, 1'b1);
    wait_bytes(256);
    repeat (1500) @(negedge clk);
    chk(rx_count == 256, "R6 dropped command count", rx_count, 256);
    chk(got[255] == mem_val(15'h12FF, salt), "R6 last byte page", got[255], mem_val(15'h12FF, salt));
    chk(addr == 15'h12FF, "R6 address after drop", addr, 15'h12FF);

    // R7: bad stop bit ignored
    rx_count = 0;
    a_before = addr;
    send(8'h33, 1'b0);
    repeat (600) @(negedge clk);
    chk(rx_count == 0, "R7 no response", rx_count, 0);
    chk(addr == a_before, "R7 address unchanged", addr, a_before);
    // recovery after framing error, R5 framing
    run_page(8'h5C, "R7_recover_R5");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule